// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

A synchronous binary counter that moves up or down by one on each rising clock edge while both of its active-low count enables are asserted. A synchronous active-low load copies a parallel data word into the register instead. The count direction follows a single level input. Every state change takes place at the clock edge, and all bits of the register change together.

An active-low carry flags the terminal count of the current direction. The terminal count is all ones when counting up and all zeros when counting down. The carry is decoded combinationally from the register, the direction input and the T enable, with no register delay. Only the T enable gates the carry; the P enable does not. Wiring one stage's carry into the next stage's T enable builds a wider synchronous counter without any extra gating.

The register has no reset and powers up unknown, so a load must come before the count is relied on.

Top module: `updn_counter`

## Requirements
- R1: The count register changes only on a rising clock edge. Changing load, enables, direction or data between edges leaves the count output unchanged until the next edge.
- R2: When load_n is 0 at a rising edge, the count takes the value of d at that edge. This happens whatever the levels of the enables and the direction.
- R3: With load_n at 1, the count holds its value at an edge when en_p_n or en_t_n is 1. It counts only when both are 0.
- R4: With load_n at 1, both enables at 0 and up at 1, the count increments by one. It wraps from 15 to 0.
- R5: With load_n at 1, both enables at 0 and up at 0, the count decrements by one. It wraps from 0 to 15.
- R6: carry_n is 0 exactly when en_t_n is 0 and the count is at the terminal value of the current direction: 15 with up at 1, 0 with up at 0. It is 1 otherwise, and en_p_n has no effect on it.
- R7: carry_n follows changes of the count, up and en_t_n within the same cycle, without waiting for a clock edge.
- R8: Stages chained so that each carry_n drives the next stage's en_t_n form a wider counter. The first stage's en_t_n and every en_p_n act as the common enable, and the wider counter counts up and down with correct wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p_n | input | 1 | Count enable P, active low |
| en_t_n | input | 1 | Count enable T, active low; also gates the carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| d | input | WIDTH | Parallel load data |
| q | output | WIDTH | Count value |
| carry_n | output | 1 | Terminal-count carry, active low |

## Verification
The single stage is driven with a constrained random mix of load, hold through either enable, and up and down counting. This separates the load priority from the enable gating and from the direction.

Directed cases start from 15 and from 0 in both directions. They tell the wrap behaviour apart from a plain hold or load. They also hold P high at a terminal count to show that only T gates the carry.

Each carry is checked mid-cycle, right after its inputs change, which separates a combinational decode from a registered one. A three-stage chain is run across its 12-bit wrap points, where a carry that is wrongly gated or delayed would break the wide count.

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  input  logic             up,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             carry_n
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic count_en;
  logic at_term;

  assign count_en = ~en_p_n & ~en_t_n;
  assign at_term  = up ? (&q) : ~(|q);
  assign carry_n  = ~(at_term & ~en_t_n);

  always_ff @(posedge clk) begin
    if (!load_n)
      q <= d;
    else if (count_en)
      q <= up ? q + ONE : q - ONE;
  end

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff ($isunknown(d))
    !load_n |=> q == $past(d)); // R2

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff ($isunknown(q))
    (load_n && (en_p_n || en_t_n)) |=> $stable(q)); // R3

  AST_COUNT_UP: assert property (@(posedge clk) disable iff ($isunknown(q))
    (load_n && !en_p_n && !en_t_n && up) |=> q == WIDTH'($past(q) + ONE)); // R4

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff ($isunknown(q))
    (load_n && !en_p_n && !en_t_n && !up) |=> q == WIDTH'($past(q) - ONE)); // R5

  AST_CARRY_GATED_BY_T: assert property (@(posedge clk) disable iff ($isunknown(q))
    en_t_n |-> carry_n); // R6

  AST_CARRY_PREDICTS_WRAP: assert property (@(posedge clk) disable iff ($isunknown(q))
    (!carry_n && load_n && !en_p_n) |=> (q == (up ? '0 : '1)) || (up != $past(up))); // R8

endmodule

// File: tb/updn_counter_bench.sv
`timescale 1ns/1ps
module updn_counter_bench;

  localparam int NST = 3;
  localparam int CW  = 4 * NST;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       load_n, p_n, t_n, up;
  logic [3:0] d;
  logic [3:0] q;
  logic       carry_n;

  updn_counter #(.WIDTH(4)) u_updn_counter (
    .clk(clk), .load_n(load_n), .en_p_n(p_n), .en_t_n(t_n), .up(up),
    .d(d), .q(q), .carry_n(carry_n)
  );

  logic          c_load_n, c_en_n, c_up;
  logic [CW-1:0] c_d;
  logic [CW-1:0] c_q;
  logic [NST-1:0] c_carry;
  logic [NST-1:0] c_tn;

  for (genvar i = 0; i < NST; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign c_tn[i] = c_en_n;
    end else begin : g_next
      assign c_tn[i] = c_carry[i-1];
    end
    updn_counter #(.WIDTH(4)) u_stage (
      .clk(clk), .load_n(c_load_n), .en_p_n(c_en_n), .en_t_n(c_tn[i]), .up(c_up),
      .d(c_d[4*i +: 4]), .q(c_q[4*i +: 4]), .carry_n(c_carry[i])
    );
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [3:0]    exp_q;
  logic [CW-1:0] exp_c;

  function automatic logic [3:0] nxt4(logic [3:0] c, logic l, logic p, logic t, logic u, logic [3:0] dv);
    if (!l) return dv;
    if (!p && !t) return u ? c + 4'd1 : c - 4'd1;
    return c;
  endfunction

  function automatic logic cy4(logic [3:0] c, logic u, logic t);
    return !(!t && (u ? (c == 4'hF) : (c == 4'h0)));
  endfunction

  function automatic logic [CW-1:0] nxtc(logic [CW-1:0] c, logic l, logic e, logic u, logic [CW-1:0] dv);
    if (!l) return dv;
    if (!e) return u ? c + CW'(1) : c - CW'(1);
    return c;
  endfunction

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic step(input logic l, input logic p, input logic t, input logic u, input logic [3:0] dv,
                      input bool_known);
  endtask

  task automatic st(input logic l, input logic p, input logic t, input logic u, input logic [3:0] dv,
                    input bit known);
    load_n = l; p_n = p; t_n = t; up = u; d = dv;
    #1;
    if (known) begin
      chk("R1 count unchanged before edge", CW'(q), CW'(exp_q));
      chk("R7 carry same cycle", CW'(carry_n), CW'(cy4(exp_q, u, t)));
    end
    @(negedge clk);
    exp_q = nxt4(exp_q, l, p, t, u, dv);
    if (!l)                 chk("R2 load", CW'(q), CW'(exp_q));
    else if (p || t)        chk("R3 hold", CW'(q), CW'(exp_q));
    else if (u)             chk("R4 up", CW'(q), CW'(exp_q));
    else                    chk("R5 down", CW'(q), CW'(exp_q));
  endtask

  task automatic cst(input logic l, input logic e, input logic u, input logic [CW-1:0] dv, input bit known);
    c_load_n = l; c_en_n = e; c_up = u; c_d = dv;
    #1;
    if (known)
      chk("R8 chain carry", CW'(c_carry[NST-1]),
          CW'(!(!e && (u ? (exp_c == '1) : (exp_c == '0)))));
    @(negedge clk);
    exp_c = nxtc(exp_c, l, e, u, dv);
    chk("R8 chain count", c_q, exp_c);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    exp_q = 'x; exp_c = 'x;
    load_n = 1; p_n = 1; t_n = 1; up = 1; d = 0;
    c_load_n = 1; c_en_n = 1; c_up = 1; c_d = 0;
    @(negedge clk);

    st(0, 1, 1, 1, 4'hD, 0);
    st(1, 0, 0, 1, 4'h0, 1);
    st(1, 0, 0, 1, 4'h3, 1);
    st(1, 0, 0, 1, 4'h3, 1);
    st(0, 0, 0, 0, 4'h0, 1);
    st(1, 0, 0, 0, 4'h7, 1);
    st(1, 1, 0, 0, 4'h7, 1);
    st(1, 0, 1, 0, 4'h7, 1);
    st(0, 1, 1, 1, 4'hF, 1);
    load_n = 1; p_n = 1; t_n = 0; up = 1; #1;
    chk("R6 P high does not block carry", CW'(carry_n), 0);
    t_n = 1; #0.5;
    chk("R6 T high blocks carry", CW'(carry_n), 1);
    up = 0; t_n = 0; #0.5;
    chk("R6 carry follows direction", CW'(carry_n), 1);
    @(negedge clk);

    for (int i = 0; i < 600; i++) begin
      logic l, p, t, u;
      l = ($urandom % 8) != 0;
      p = ($urandom % 5) == 0;
      t = ($urandom % 5) == 0;
      u = $urandom % 2;
      st(l, p, t, u, 4'($urandom), 1);
    end

    cst(0, 1, 1, 12'hFFE, 0);
    for (int i = 0; i < 4; i++) cst(1, 0, 1, 0, 1);
    cst(1, 1, 1, 0, 1);
    cst(0, 1, 0, 12'h002, 1);
    for (int i = 0; i < 4; i++) cst(1, 0, 0, 0, 1);
    cst(0, 1, 1, 12'h0FE, 1);
    for (int i = 0; i < 3; i++) cst(1, 0, 1, 0, 1);
    for (int i = 0; i < 3; i++) cst(1, 0, 0, 0, 1);
    for (int i = 0; i < 300; i++) begin
      logic l, e, u;
      l = ($urandom % 16) != 0;
      e = ($urandom % 6) == 0;
      u = $urandom % 2;
      cst(l, e, u, CW'($urandom), 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule